// File: doc/BRIEF.md
# Quadrature Position Decoder

This block turns a pair of quadrature phase signals and an index pulse into a signed-free, wrap-around position count. Every legal change of either phase moves the count by one, so one full quadrature cycle gives four counts. A direction flag follows the most recent legal move. A transition in which both phases change between two samples cannot be decoded. It is reported on a phase-error flag and leaves the count alone.

Two reset schemes are available. The scheme is chosen while the block is idle. In ceiling mode the count wraps between zero and a programmable ceiling. In index mode the count runs over the full register range, and an active index edge clears it. That edge is accepted only when the decoded phase levels equal a programmed 2-bit pattern. Six event sources set sticky interrupt status bits: ceiling or index resets in each direction, direction reversals, and three sources that enter from neighbouring logic. Each bit can be masked, and writing a 1 to a bit clears it. The phase inputs are expected to be synchronised and de-glitched upstream.

Top module: `qdec_top`

## Requirements
- R1: After reset the count is 0, the direction flag reads up (1), the phase-error flag is 0, all interrupt status bits are 0 and the interrupt line is low; the configuration resets to ceiling mode with an all-ones ceiling, no swap, no inversion and gate pattern 0.
- R2: With `en` high, each legal change of the decoded pair {A,B} moves the count by one: the order 00→10→11→01→00 (A leading B) counts up and the reverse order counts down. The count reflects a pin change after two rising clock edges. With `en` low the count and the direction flag do not change.
- R3: When the swap setting is 1, pin B is decoded as phase A and pin A as phase B, so a rise of pin A alone from pins 00 counts down.
- R4: The A, B and index inversion settings each invert their input after the swap. With A inverted, a rise of pin A from pins 00 counts down.
- R5: In index mode (reset-mode setting 0), a rising edge of the decoded index clears the count to 0, but only when the decoded levels {A,B} equal the gate pattern: 0 = A low/B low, 1 = A low/B high, 2 = A high/B low, 3 = A high/B high. With index inversion, the falling pin edge is the active one. The index clear takes priority over a phase move in the same cycle and raises the reset event of the current direction.
- R6: In ceiling mode (reset-mode setting 1), counting up from a value at or above the ceiling gives 0 and raises the up-reset event (status bit 2). Counting down from 0 gives the ceiling and raises the down-reset event (status bit 1). The index input has no effect.
- R7: In index mode the ceiling is not used, and counting passes the ceiling value without wrapping.
- R8: An illegal transition, in which both A and B change between two samples, sets `phase_err` and leaves the count unchanged. The flag stays set while `en` is high and clears once `en` is low.
- R9: `dir_up` holds the direction of the last legal move. A move opposite to the held direction raises the direction-change event (status bit 3).
- R10: Status bit positions: 0 watchdog input, 1 down-reset, 2 up-reset, 3 direction change, 4 FIFO-entry input, 5 FIFO-critical input. A source sets its bit only when its mask bit is 0. A set bit stays set until a 1 is written to its position in `irq_clr`. `irq` is high while any status bit is set.
- R11: A configuration write (`cfg_we`) takes effect only while `en` is low. A write made while `en` is high changes nothing, and the old ceiling and mode stay in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counting enable; configuration is frozen while high |
| pin_a | input | 1 | Phase A input |
| pin_b | input | 1 | Phase B input |
| pin_idx | input | 1 | Index input |
| cfg_we | input | 1 | Load the cfg_* values (accepted only while en is low) |
| cfg_swap | input | 1 | Exchange the A and B pins before decoding |
| cfg_inv_a | input | 1 | Invert decoded phase A |
| cfg_inv_b | input | 1 | Invert decoded phase B |
| cfg_inv_idx | input | 1 | Invert the index input |
| cfg_gate | input | 2 | Required {A,B} levels for an index clear |
| cfg_ceil_mode | input | 1 | 1 = ceiling wrap, 0 = gated index clear |
| cfg_ceiling | input | CNT_W | Ceiling value |
| ext_wdog | input | 1 | Watchdog event from neighbouring logic |
| ext_fifo_entry | input | 1 | FIFO-entry event from neighbouring logic |
| ext_fifo_crit | input | 1 | FIFO-critical event from neighbouring logic |
| irq_mask | input | 6 | A 1 blocks the matching status bit |
| irq_clr | input | 6 | Write-one-to-clear for status bits |
| count | output | CNT_W | Position count |
| dir_up | output | 1 | Direction of the last legal move, 1 = up |
| phase_err | output | 1 | An illegal transition has been seen since enable |
| irq_status | output | 6 | Sticky interrupt status |
| irq | output | 1 | OR of the status bits |

## Verification
A fault in the sampling registers or in the transition decode shows up two clock edges after the pin change. It appears as a count that is off by one, a wrong `dir_up`, or a spurious direction-change bit. A fault in the wrap or index logic shows only at the boundary moves: the step past the ceiling, the step below zero, or an index edge under the matching or non-matching gate. Those points are therefore driven on purpose, in addition to a long random walk. A fault in the configuration freeze stays hidden until the next wrap, which then lands at the wrong ceiling. For this reason the bench keeps counting well past the old ceiling after a write made while enabled.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    localparam int unsigned IRQ_W         = 6;
    localparam int unsigned IRQ_WDOG      = 0;
    localparam int unsigned IRQ_RST_DN    = 1;
    localparam int unsigned IRQ_RST_UP    = 2;
    localparam int unsigned IRQ_DIR       = 3;
    localparam int unsigned IRQ_FIFO_ENT  = 4;
    localparam int unsigned IRQ_FIFO_CRIT = 5;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2,
        STEP_BAD  = 2'd3
    } step_e;

    typedef struct packed {
        logic a;
        logic b;
        logic idx;
    } phase_t;

    typedef struct packed {
        logic       swap;
        logic       inv_a;
        logic       inv_b;
        logic       inv_idx;
        logic [1:0] gate;
        logic       ceil_mode;
    } qcfg_t;

    localparam qcfg_t CFG_RESET = '{swap: 1'b0, inv_a: 1'b0, inv_b: 1'b0,
                                    inv_idx: 1'b0, gate: 2'd0, ceil_mode: 1'b1};

    // Forward order of {A,B}: 00 -> 10 -> 11 -> 01 -> 00
    function automatic logic [1:0] fwd_next(input logic [1:0] ab);
        case (ab)
            2'b00:   fwd_next = 2'b10;
            2'b10:   fwd_next = 2'b11;
            2'b11:   fwd_next = 2'b01;
            default: fwd_next = 2'b00;
        endcase
    endfunction

    function automatic step_e decode_step(input logic [1:0] prv, input logic [1:0] cur);
        step_e s;
        if (prv == cur)                  s = STEP_NONE;
        else if ((prv ^ cur) == 2'b11)   s = STEP_BAD;
        else if (fwd_next(prv) == cur)   s = STEP_UP;
        else                             s = STEP_DN;
        return s;
    endfunction

    function automatic logic gate_match(input logic [1:0] gate, input logic a, input logic b);
        return gate == {a, b};
    endfunction

endpackage

// File: rtl/qdec_cfg_regs.sv
module qdec_cfg_regs
    import qdec_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             we,
    input  qcfg_t            cfg_in,
    input  logic [CNT_W-1:0] ceil_in,
    output qcfg_t            cfg_q,
    output logic [CNT_W-1:0] ceil_q
);

    localparam logic [CNT_W-1:0] CEIL_RESET = '1;

    logic load;
    assign load = we && !en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            ceil_q <= CEIL_RESET;
        end else if (load) begin
            cfg_q  <= cfg_in;
            ceil_q <= ceil_in;
        end
    end

endmodule

// File: rtl/qdec_front.sv
module qdec_front
    import qdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_a,
    input  logic  pin_b,
    input  logic  pin_idx,
    input  qcfg_t cfg,
    output step_e step,
    output logic  idx_hit
);

    phase_t cond;
    phase_t cur_q;
    phase_t prv_q;

    // swap first, then per-phase inversion
    always_comb begin
        cond.a   = (cfg.swap ? pin_b : pin_a) ^ cfg.inv_a;
        cond.b   = (cfg.swap ? pin_a : pin_b) ^ cfg.inv_b;
        cond.idx = pin_idx ^ cfg.inv_idx;
    end

    // both stages load the live levels in reset so no phantom step follows
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= cond;
            prv_q <= cond;
        end else begin
            cur_q <= cond;
            prv_q <= cur_q;
        end
    end

    assign step    = decode_step({prv_q.a, prv_q.b}, {cur_q.a, cur_q.b});
    assign idx_hit = cur_q.idx && !prv_q.idx && gate_match(cfg.gate, cur_q.a, cur_q.b);

endmodule

// File: rtl/qdec_position.sv
module qdec_position
    import qdec_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  step_e            step,
    input  logic             idx_hit,
    input  logic             ceil_mode,
    input  logic [CNT_W-1:0] ceiling,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             phase_err,
    output logic             ev_rst_up,
    output logic             ev_rst_dn,
    output logic             ev_dir
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             dir_q, dir_d;
    logic             err_q, err_d;

    always_comb begin
        cnt_d     = cnt_q;
        dir_d     = dir_q;
        err_d     = err_q;
        ev_rst_up = 1'b0;
        ev_rst_dn = 1'b0;
        ev_dir    = 1'b0;
        if (!en) begin
            err_d = 1'b0;
        end else begin
            if (!ceil_mode && idx_hit) begin
                cnt_d     = ZERO;
                ev_rst_up = dir_q;
                ev_rst_dn = !dir_q;
            end else if (step == STEP_UP) begin
                if (ceil_mode && cnt_q >= ceiling) begin
                    cnt_d     = ZERO;
                    ev_rst_up = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else if (step == STEP_DN) begin
                if (ceil_mode && cnt_q == ZERO) begin
                    cnt_d     = ceiling;
                    ev_rst_dn = 1'b1;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            case (step)
                STEP_UP: begin
                    dir_d  = 1'b1;
                    ev_dir = !dir_q;
                end
                STEP_DN: begin
                    dir_d  = 1'b0;
                    ev_dir = dir_q;
                end
                STEP_BAD: err_d = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ZERO;
            dir_q <= 1'b1;
            err_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
            err_q <= err_d;
        end
    end

    assign count     = cnt_q;
    assign dir_up    = dir_q;
    assign phase_err = err_q;

endmodule

// File: rtl/qdec_irq.sv
module qdec_irq #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status,
    output logic         irq
);

    logic [N-1:0] st_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                      st_q[i] <= 1'b0;
            else if (src[i] && !mask[i])  st_q[i] <= 1'b1;
            else if (clr[i])              st_q[i] <= 1'b0;
        end
    end

    assign status = st_q;
    assign irq    = |st_q;

endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             pin_idx,
    input  logic             cfg_we,
    input  logic             cfg_swap,
    input  logic             cfg_inv_a,
    input  logic             cfg_inv_b,
    input  logic             cfg_inv_idx,
    input  logic [1:0]       cfg_gate,
    input  logic             cfg_ceil_mode,
    input  logic [CNT_W-1:0] cfg_ceiling,
    input  logic             ext_wdog,
    input  logic             ext_fifo_entry,
    input  logic             ext_fifo_crit,
    input  logic [5:0]       irq_mask,
    input  logic [5:0]       irq_clr,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             phase_err,
    output logic [5:0]       irq_status,
    output logic             irq
);

    qcfg_t            cfg_in, cfg_q;
    logic [CNT_W-1:0] ceil_q;
    step_e            step;
    logic             idx_hit;
    logic             ev_rst_up, ev_rst_dn, ev_dir;
    logic [IRQ_W-1:0] irq_src;

    always_comb begin
        cfg_in.swap      = cfg_swap;
        cfg_in.inv_a     = cfg_inv_a;
        cfg_in.inv_b     = cfg_inv_b;
        cfg_in.inv_idx   = cfg_inv_idx;
        cfg_in.gate      = cfg_gate;
        cfg_in.ceil_mode = cfg_ceil_mode;
    end

    qdec_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .we      (cfg_we),
        .cfg_in  (cfg_in),
        .ceil_in (cfg_ceiling),
        .cfg_q   (cfg_q),
        .ceil_q  (ceil_q)
    );

    qdec_front u_front (
        .clk     (clk),
        .rst     (rst),
        .pin_a   (pin_a),
        .pin_b   (pin_b),
        .pin_idx (pin_idx),
        .cfg     (cfg_q),
        .step    (step),
        .idx_hit (idx_hit)
    );

    qdec_position #(.CNT_W(CNT_W)) u_pos (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .step      (step),
        .idx_hit   (idx_hit),
        .ceil_mode (cfg_q.ceil_mode),
        .ceiling   (ceil_q),
        .count     (count),
        .dir_up    (dir_up),
        .phase_err (phase_err),
        .ev_rst_up (ev_rst_up),
        .ev_rst_dn (ev_rst_dn),
        .ev_dir    (ev_dir)
    );

    always_comb begin
        irq_src                = '0;
        irq_src[IRQ_WDOG]      = ext_wdog;
        irq_src[IRQ_RST_DN]    = ev_rst_dn;
        irq_src[IRQ_RST_UP]    = ev_rst_up;
        irq_src[IRQ_DIR]       = ev_dir;
        irq_src[IRQ_FIFO_ENT]  = ext_fifo_entry;
        irq_src[IRQ_FIFO_CRIT] = ext_fifo_crit;
    end

    qdec_irq #(.N(IRQ_W)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .src    (irq_src),
        .mask   (irq_mask),
        .clr    (irq_clr),
        .status (irq_status),
        .irq    (irq)
    );

endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] ceil_q,
    input logic             dir_up,
    input logic             phase_err,
    input logic             idx_hit,
    input logic             ev_dir,
    input logic [5:0]       irq_status,
    input logic [5:0]       irq_mask,
    input logic [5:0]       irq_clr
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (count == '0 && irq_status == '0 && !phase_err && dir_up)); // R1

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count)); // R2

    AST_ERR_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        ($rose(phase_err) && !$past(idx_hit)) |-> $stable(count)); // R8

    AST_DIR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        ev_dir |=> (dir_up != $past(dir_up))); // R9

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_status & $past(irq_status & ~irq_clr)) == $past(irq_status & ~irq_clr)); // R10

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (irq_status & ~$past(irq_status) & $past(irq_mask)) == 6'd0); // R10

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(ceil_q)); // R11

endmodule

bind qdec_top qdec_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .count      (count),
    .ceil_q     (ceil_q),
    .dir_up     (dir_up),
    .phase_err  (phase_err),
    .idx_hit    (idx_hit),
    .ev_dir     (ev_dir),
    .irq_status (irq_status),
    .irq_mask   (irq_mask),
    .irq_clr    (irq_clr)
);

// File: tb/tb_qdec_top.sv
module tb_qdec_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          pin_a = 1'b0, pin_b = 1'b0, pin_idx = 1'b0;
    logic          cfg_we = 1'b0, cfg_swap = 1'b0, cfg_inv_a = 1'b0, cfg_inv_b = 1'b0;
    logic          cfg_inv_idx = 1'b0, cfg_ceil_mode = 1'b1;
    logic [1:0]    cfg_gate = 2'd0;
    logic [CW-1:0] cfg_ceiling = '1;
    logic          ext_wdog = 1'b0, ext_fifo_entry = 1'b0, ext_fifo_crit = 1'b0;
    logic [5:0]    irq_mask = 6'd0, irq_clr = 6'd0;
    logic [CW-1:0] count;
    logic          dir_up, phase_err, irq;
    logic [5:0]    irq_status;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdec_top #(.CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .en(en), .pin_a(pin_a), .pin_b(pin_b), .pin_idx(pin_idx),
        .cfg_we(cfg_we), .cfg_swap(cfg_swap), .cfg_inv_a(cfg_inv_a), .cfg_inv_b(cfg_inv_b),
        .cfg_inv_idx(cfg_inv_idx), .cfg_gate(cfg_gate), .cfg_ceil_mode(cfg_ceil_mode),
        .cfg_ceiling(cfg_ceiling), .ext_wdog(ext_wdog), .ext_fifo_entry(ext_fifo_entry),
        .ext_fifo_crit(ext_fifo_crit), .irq_mask(irq_mask), .irq_clr(irq_clr),
        .count(count), .dir_up(dir_up), .phase_err(phase_err),
        .irq_status(irq_status), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;

    // bench copy of the accepted configuration
    bit            t_swap = 0, t_ia = 0, t_ib = 0, t_ii = 0, t_cmode = 1;
    bit [1:0]      t_gate = 0;
    logic [CW-1:0] t_ceil = '1;
    logic [CW-1:0] exp_cnt = '0;
    bit            exp_dir = 1;
    bit [1:0]      ab = 2'b00;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit [1:0] cond_of(input bit pa, input bit pb);
        bit ca, cb;
        ca = (t_swap ? pb : pa) ^ t_ia;
        cb = (t_swap ? pa : pb) ^ t_ib;
        return {ca, cb};
    endfunction

    // position in the forward sequence 00,10,11,01
    function automatic bit [1:0] seq_pos(input bit [1:0] s);
        case (s)
            2'b00: return 2'd0;
            2'b10: return 2'd1;
            2'b11: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic bit [1:0] seq_at(input bit [1:0] p);
        case (p)
            2'd0: return 2'b00;
            2'd1: return 2'b10;
            2'd2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic drive_cond(input bit [1:0] c);
        if (!t_swap) begin
            pin_a = c[1] ^ t_ia;
            pin_b = c[0] ^ t_ib;
        end else begin
            pin_b = c[1] ^ t_ia;
            pin_a = c[0] ^ t_ib;
        end
        ab = c;
    endtask

    task automatic clear_irq();
        irq_clr = 6'h3f;
        @(negedge clk);
        irq_clr = 6'h00;
    endtask

    // apply model for one legal move, then compare count, direction and events
    task automatic model_and_check(input bit up, input string req);
        bit evu = 0, evd = 0, evc = 0;
        if (en) begin
            evc = (up != exp_dir);
            if (up) begin
                if (t_cmode && exp_cnt >= t_ceil) begin exp_cnt = '0; evu = 1; end
                else exp_cnt = exp_cnt + 1;
            end else begin
                if (t_cmode && exp_cnt == '0) begin exp_cnt = t_ceil; evd = 1; end
                else exp_cnt = exp_cnt - 1;
            end
            exp_dir = up;
        end
        chk({req, " count"}, count, exp_cnt);
        chk("R9 direction flag", dir_up, exp_dir);
        chk("R6 R9 event bits", irq_status & 6'b001110, {2'b00, evc, evu, evd, 1'b0});
        clear_irq();
    endtask

    task automatic step(input bit up);
        bit [1:0] p;
        p = seq_pos(ab) + (up ? 2'd1 : 2'd3);
        drive_cond(seq_at(p));
        repeat (2) @(negedge clk);
        model_and_check(up, en ? "R2 R6 step" : "R2 disabled");
    endtask

    task automatic raw_move(input bit pa, input bit pb, input bit up, input string req);
        pin_a = pa;
        pin_b = pb;
        ab = cond_of(pa, pb);
        repeat (2) @(negedge clk);
        model_and_check(up, req);
    endtask

    task automatic walk_to(input bit [1:0] target);
        for (int k = 0; k < 4; k++) if (ab != target) step(1'b1);
    endtask

    task automatic write_cfg(input bit sw, input bit ia, input bit ib, input bit ii,
                             input bit [1:0] g, input bit m, input logic [CW-1:0] ce);
        cfg_swap = sw; cfg_inv_a = ia; cfg_inv_b = ib; cfg_inv_idx = ii;
        cfg_gate = g; cfg_ceil_mode = m; cfg_ceiling = ce;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!en) begin
            t_swap = sw; t_ia = ia; t_ib = ib; t_ii = ii;
            t_gate = g; t_cmode = m; t_ceil = ce;
        end
        ab = cond_of(pin_a, pin_b);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_en(input bit v);
        en = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic idx_level(input bit v);
        pin_idx = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_ext(input int which);
        case (which)
            0: ext_wdog = 1'b1;
            4: ext_fifo_entry = 1'b1;
            default: ext_fifo_crit = 1'b1;
        endcase
        @(negedge clk);
        ext_wdog = 1'b0; ext_fifo_entry = 1'b0; ext_fifo_crit = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7919));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 dir_up", dir_up, 1);
        chk("R1 phase_err", phase_err, 0);
        chk("R1 irq_status", irq_status, 0);
        chk("R1 irq", irq, 0);

        // R6 ceiling mode, random walk around a small ceiling
        write_cfg(0, 0, 0, 0, 2'd0, 1, 32'd10);
        set_en(1);
        for (int i = 0; i < 200; i++) step(1'($urandom_range(0, 1)));
        for (int i = 0; i < 12; i++) step(1'b1);
        for (int i = 0; i < 12; i++) step(1'b0);

        // R6 index has no effect in ceiling mode (gate 0 matches at 00)
        walk_to(2'b00);
        idx_level(1);
        chk("R6 index ignored in ceiling mode", count, exp_cnt);
        chk("R6 no reset event from index", irq_status, 0);
        idx_level(0);

        // R11 write while enabled is dropped: wraps stay at ceiling 10
        write_cfg(0, 0, 0, 0, 2'd0, 1, 32'd3);
        for (int i = 0; i < 14; i++) step(1'b1);
        chk("R11 ceiling unchanged by enabled write", count, exp_cnt);

        // R2 disabled: pins move, count holds
        set_en(0);
        for (int i = 0; i < 6; i++) step(1'($urandom_range(0, 1)));

        // R11 write while disabled is taken
        write_cfg(0, 0, 0, 0, 2'd0, 1, 32'd3);
        set_en(1);
        for (int i = 0; i < 40; i++) step(1'($urandom_range(0, 1)));

        // R8 illegal transition
        pin_a = ~pin_a;
        pin_b = ~pin_b;
        ab = cond_of(pin_a, pin_b);
        repeat (2) @(negedge clk);
        chk("R8 phase_err set", phase_err, 1);
        chk("R8 count unchanged", count, exp_cnt);
        clear_irq();
        step(1'b1);
        chk("R8 phase_err held while enabled", phase_err, 1);
        set_en(0);
        chk("R8 phase_err cleared when disabled", phase_err, 0);

        // R3 swap: pin A rise from pins 00 counts down
        write_cfg(1, 0, 0, 0, 2'd0, 1, 32'd100);
        set_en(1);
        walk_to(2'b00);
        chk("R3 pins at 00", {pin_a, pin_b}, 2'b00);
        raw_move(1'b1, 1'b0, 1'b0, "R3 swapped A rise");

        // R4 inverted A: pin A rise from pins 00 counts down
        set_en(0);
        write_cfg(0, 1, 0, 0, 2'd0, 1, 32'd100);
        set_en(1);
        walk_to(2'b10);
        chk("R4 pins at 00", {pin_a, pin_b}, 2'b00);
        raw_move(1'b1, 1'b0, 1'b0, "R4 inverted A rise");

        // R7 index mode: no wrap at ceiling 3
        set_en(0);
        write_cfg(0, 0, 0, 0, 2'd2, 0, 32'd3);
        set_en(1);
        walk_to(2'b00);
        exp_cnt = exp_cnt;
        for (int i = 0; i < 8; i++) step(1'b1);
        chk("R7 counted past ceiling", count > 32'd3, 1);

        // R5 gate mismatch (state 00, gate 2) blocks the clear
        idx_level(1);
        chk("R5 gated-off index", count, exp_cnt);
        idx_level(0);
        step(1'b1);
        chk("R5 at gate state", ab, 2'b10);
        idx_level(1);
        exp_cnt = '0;
        chk("R5 index clear", count, 0);
        chk("R5 up reset event", irq_status[2], 1);
        clear_irq();
        idx_level(0);

        // R5 inverted index: falling pin edge is active
        set_en(0);
        write_cfg(0, 0, 0, 1, 2'd2, 0, 32'd3);
        set_en(1);
        for (int i = 0; i < 4; i++) step(1'b1);
        idx_level(1);
        chk("R5 inverted index, pin rise ignored", count, 4);
        idx_level(0);
        exp_cnt = '0;
        chk("R5 inverted index, pin fall clears", count, 0);
        clear_irq();

        // R10 interrupt sources, mask, stickiness and write-one-to-clear
        irq_mask = 6'b000001;
        pulse_ext(0);
        chk("R10 masked watchdog", irq_status, 0);
        pulse_ext(4);
        pulse_ext(5);
        chk("R10 fifo bits set", irq_status, 6'b110000);
        chk("R10 irq line", irq, 1);
        repeat (5) @(negedge clk);
        chk("R10 sticky", irq_status, 6'b110000);
        irq_clr = 6'b010000;
        @(negedge clk);
        irq_clr = 6'b000000;
        chk("R10 clear one bit", irq_status, 6'b100000);
        irq_mask = 6'b000000;
        pulse_ext(0);
        chk("R10 unmasked watchdog", irq_status, 6'b100001);
        clear_irq();
        chk("R10 all cleared", irq_status, 0);
        chk("R10 irq low", irq, 0);

        summary();
        $finish;
    end

endmodule